// File: doc/BRIEF.md
# SDRAM Command Decoder and Sequence Checker

This block watches the command pins of a four-bank single-data-rate SDRAM. On every rising clock it samples chip select, the row and column strobes, write enable, the two bank-select bits, the address bus and the clock enable. It compares the clock enable with the value it held on the previous edge. The sampled pattern is decoded into a command code. The block also keeps an idle or active state for each bank. Along with the code it reports the selected bank, row, column and auto-precharge request.

Beyond decoding, the block enforces sequencing rules. Mode-register loads, refresh and self-refresh entry require every bank to be idle. A mode-register load is followed by a two-cycle quiet window. A bank that is running an auto-precharge burst cannot be addressed again until it has closed. After deep power-down, the device must be re-initialised. A command that breaks a rule raises the error output for one cycle and does not change any tracked state.

All decoded outputs are registered. They appear one clock after the edge that sampled the pins. The bank state output shows the state after that same edge.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With clock enable high on both the previous and the current edge, the pins decode as follows. Chip select high gives DESEL=0. With chip select low, the pattern {ras,cas,we} decodes as: 111 NOP=1, 000 mode load (MRS=2, or EMRS=3 when bank-select bit 1 is high), 011 ACT=4, 101 READ=5, 100 WRITE=6, 010 PRE=7 (PREALL=8 when address bit 10 is high), 001 REF=9, 110 BST=10. The result is on cmd_o one clock later.
- R2: A clock enable that falls decodes by pattern. The refresh pattern gives SREF_IN=11, the burst-stop pattern gives DPD_IN=15, and any other pattern gives PDN_IN=13. A clock enable that rises decodes by the low-power state entered last: SREF_OUT=12, DPD_OUT=16, or PDN_OUT=14. A clock enable that stays low gives LOWPWR=17.
- R3: bank_o carries the bank-select bits and row_o carries the full address. col_o carries address bits 9:0. ap_o is address bit 10 on READ and WRITE and 0 otherwise. PREALL closes all four banks whatever the bank bits are.
- R4: MRS, EMRS, REF and SREF_IN are flagged on err_o when any bank is active.
- R5: During the 2 cycles after an accepted MRS or EMRS, any command other than NOP or DESEL is flagged.
- R6: An accepted ACT opens the selected bank and an accepted PRE closes it. bank_active_o bit n shows bank n. A READ or WRITE to an idle bank is flagged.
- R7: While a bank runs an auto-precharge burst, a READ or WRITE to that bank is flagged, while one to another open bank is accepted. The bank closes burst-length plus one edges after its command, and on the closing edge it still counts as active.
- R8: The burst length comes from address bits 2:0 of the last accepted MRS. Code 0 gives 1, code 1 gives 2, code 2 gives 4, and any other code gives 8. After reset the burst length is 1.
- R9: After DPD_OUT, every command other than NOP, DESEL, MRS and EMRS is flagged until an MRS is accepted. DPD_OUT closes all banks.
- R10: A flagged command leaves the bank state, the mode value, the quiet window and the re-initialisation state unchanged. After reset, cmd_o is DESEL, err_o is 0 and all banks are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable pin |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 12 | Address bus |
| cmd_o | output | 5 | Decoded command code |
| bank_o | output | 2 | Decoded bank |
| row_o | output | 12 | Row address |
| col_o | output | 10 | Column address |
| ap_o | output | 1 | Auto-precharge request on read or write |
| err_o | output | 1 | Sequencing violation |
| bank_active_o | output | 4 | Per-bank open state |

## Verification
Two functions can act on the same edge: the expiry of an auto-precharge countdown and the all-idle check for a refresh. The bench provokes this by issuing a refresh on exactly the edge where a bank's burst-length-plus-one countdown ends. It expects the refresh to be flagged, because the bank still counts as active when the pins are sampled, and it expects the bank to read idle right after that edge. A second refresh on the next edge must then be accepted.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  typedef enum logic [4:0] {
    CMD_DESEL    = 5'd0,
    CMD_NOP      = 5'd1,
    CMD_MRS      = 5'd2,
    CMD_EMRS     = 5'd3,
    CMD_ACT      = 5'd4,
    CMD_READ     = 5'd5,
    CMD_WRITE    = 5'd6,
    CMD_PRE      = 5'd7,
    CMD_PREALL   = 5'd8,
    CMD_REF      = 5'd9,
    CMD_BST      = 5'd10,
    CMD_SREF_IN  = 5'd11,
    CMD_SREF_OUT = 5'd12,
    CMD_PDN_IN   = 5'd13,
    CMD_PDN_OUT  = 5'd14,
    CMD_DPD_IN   = 5'd15,
    CMD_DPD_OUT  = 5'd16,
    CMD_LOWPWR   = 5'd17
  } cmd_e;

  typedef enum logic [1:0] {LP_NONE, LP_SREF, LP_PDN, LP_DPD} lp_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cke_prev_i,
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic ext_sel_i,
  input  logic all_sel_i,
  input  lp_e  lp_i,
  output cmd_e cmd_o
);
  logic [2:0] strobes;
  assign strobes = {ras_ni, cas_ni, we_ni};

  always_comb begin
    cmd_o = CMD_NOP;
    if (!cke_prev_i && !cke_i) begin
      cmd_o = CMD_LOWPWR;
    end else if (!cke_prev_i) begin
      case (lp_i)
        LP_SREF: cmd_o = CMD_SREF_OUT;
        LP_DPD:  cmd_o = CMD_DPD_OUT;
        default: cmd_o = CMD_PDN_OUT;
      endcase
    end else if (!cke_i) begin
      if (!cs_ni && strobes == 3'b001)      cmd_o = CMD_SREF_IN;
      else if (!cs_ni && strobes == 3'b110) cmd_o = CMD_DPD_IN;
      else                                  cmd_o = CMD_PDN_IN;
    end else if (cs_ni) begin
      cmd_o = CMD_DESEL;
    end else begin
      case (strobes)
        3'b000:  cmd_o = ext_sel_i ? CMD_EMRS : CMD_MRS;
        3'b001:  cmd_o = CMD_REF;
        3'b010:  cmd_o = all_sel_i ? CMD_PREALL : CMD_PRE;
        3'b011:  cmd_o = CMD_ACT;
        3'b100:  cmd_o = CMD_WRITE;
        3'b101:  cmd_o = CMD_READ;
        3'b110:  cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             rwap_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             active_o,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (clr_i || pre_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (act_i) begin
      active_q <= 1'b1;
    end else if (rwap_i) begin
      cnt_q <= load_i;
    end else if (cnt_q == CNT_W'(1)) begin
      // auto-precharge completes
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign active_o = active_q;
  assign busy_o   = (cnt_q != '0);
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BANK_W   = 2,
  parameter int COL_W    = 10,
  parameter int AP_BIT   = 10,
  parameter int MRS_HOLD = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cke_i,
  input  logic                   cs_ni,
  input  logic                   ras_ni,
  input  logic                   cas_ni,
  input  logic                   we_ni,
  input  logic [BANK_W-1:0]      ba_i,
  input  logic [ADDR_W-1:0]      addr_i,
  output logic [4:0]             cmd_o,
  output logic [BANK_W-1:0]      bank_o,
  output logic [ADDR_W-1:0]      row_o,
  output logic [COL_W-1:0]       col_o,
  output logic                   ap_o,
  output logic                   err_o,
  output logic [(1<<BANK_W)-1:0] bank_active_o
);
  localparam int NBANK  = 1 << BANK_W;
  localparam int CNT_W  = 4;
  localparam int HOLD_W = $clog2(MRS_HOLD + 1);

  logic              cke_q, init_q, ap_q, err_q;
  lp_e               lp_q;
  cmd_e              cmd, cmd_q;
  logic [2:0]        mode_q;
  logic [HOLD_W-1:0] hold_q;
  logic [CNT_W-1:0]  bl_load;
  logic [NBANK-1:0]  act_v, busy_v, act_en, pre_en, rwap_en;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] row_q;
  logic              is_rw, is_quiet, is_mrs, needs_idle, ap_req, ok, clr_all;

  sdram_cmd_decode u_dec (
    .cke_prev_i (cke_q),
    .cke_i      (cke_i),
    .cs_ni      (cs_ni),
    .ras_ni     (ras_ni),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .ext_sel_i  (ba_i[BANK_W-1]),
    .all_sel_i  (addr_i[AP_BIT]),
    .lp_i       (lp_q),
    .cmd_o      (cmd)
  );

  assign ap_req     = addr_i[AP_BIT];
  assign is_rw      = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign is_quiet   = (cmd == CMD_NOP) || (cmd == CMD_DESEL);
  assign is_mrs     = (cmd == CMD_MRS) || (cmd == CMD_EMRS);
  assign needs_idle = is_mrs || (cmd == CMD_REF) || (cmd == CMD_SREF_IN);

  always_comb begin
    ok = 1'b1;
    if (needs_idle && (|act_v))                  ok = 1'b0;
    if ((hold_q != '0) && !is_quiet)             ok = 1'b0;
    if (is_rw && (!act_v[ba_i] || busy_v[ba_i])) ok = 1'b0;
    if (init_q && !is_quiet && !is_mrs)          ok = 1'b0;
  end

  assign clr_all = ok && (cmd == CMD_DPD_OUT);

  always_comb begin
    case (mode_q)
      3'd0:    bl_load = CNT_W'(2);
      3'd1:    bl_load = CNT_W'(3);
      3'd2:    bl_load = CNT_W'(5);
      default: bl_load = CNT_W'(9);
    endcase
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign act_en[b]  = ok && (cmd == CMD_ACT) && (ba_i == BANK_W'(b));
    assign pre_en[b]  = ok && ((cmd == CMD_PREALL) ||
                               ((cmd == CMD_PRE) && (ba_i == BANK_W'(b))));
    assign rwap_en[b] = ok && is_rw && ap_req && (ba_i == BANK_W'(b));

    sdram_bank_track #(.CNT_W(CNT_W)) u_trk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (act_en[b]),
      .pre_i    (pre_en[b]),
      .rwap_i   (rwap_en[b]),
      .clr_i    (clr_all),
      .load_i   (bl_load),
      .active_o (act_v[b]),
      .busy_o   (busy_v[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q  <= 1'b1;
      lp_q   <= LP_NONE;
      mode_q <= '0;
      hold_q <= '0;
      init_q <= 1'b0;
      cmd_q  <= CMD_DESEL;
      bank_q <= '0;
      row_q  <= '0;
      ap_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cke_q <= cke_i;
      // low-power state follows the pins, legal or not
      case (cmd)
        CMD_SREF_IN:                          lp_q <= LP_SREF;
        CMD_PDN_IN:                           lp_q <= LP_PDN;
        CMD_DPD_IN:                           lp_q <= LP_DPD;
        CMD_SREF_OUT, CMD_PDN_OUT, CMD_DPD_OUT: lp_q <= LP_NONE;
        default: ;
      endcase
      if (ok && is_mrs)           hold_q <= HOLD_W'(MRS_HOLD);
      else if (hold_q != '0)      hold_q <= hold_q - HOLD_W'(1);
      if (ok && cmd == CMD_MRS)   mode_q <= addr_i[2:0];
      if (clr_all)                init_q <= 1'b1;
      else if (ok && cmd == CMD_MRS) init_q <= 1'b0;
      cmd_q  <= cmd;
      bank_q <= ba_i;
      row_q  <= addr_i;
      ap_q   <= is_rw && ap_req;
      err_q  <= !ok;
    end
  end

  assign cmd_o         = cmd_q;
  assign bank_o        = bank_q;
  assign row_o         = row_q;
  assign col_o         = row_q[COL_W-1:0];
  assign ap_o          = ap_q;
  assign err_o         = err_q;
  assign bank_active_o = act_v;
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int BANK_W = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [4:0]             cmd_o,
  input logic [BANK_W-1:0]      bank_o,
  input logic                   ap_o,
  input logic                   err_o,
  input logic [(1<<BANK_W)-1:0] bank_active_o
);
  localparam int NBANK = 1 << BANK_W;
  localparam logic [4:0] C_DESEL = 5'd0, C_NOP = 5'd1, C_MRS = 5'd2, C_EMRS = 5'd3,
                         C_ACT = 5'd4, C_READ = 5'd5, C_WRITE = 5'd6,
                         C_PREALL = 5'd8, C_REF = 5'd9;

  logic ok_mode, ok_rw;
  assign ok_mode = !err_o && (cmd_o == C_MRS || cmd_o == C_EMRS);
  assign ok_rw   = !err_o && (cmd_o == C_READ || cmd_o == C_WRITE);

  AST_IDLE_FOR_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_mode || (!err_o && cmd_o == C_REF)) |-> ($past(bank_active_o) == '0)); // R4

  AST_QUIET_AFTER_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_mode |=> (err_o || cmd_o == C_NOP || cmd_o == C_DESEL)); // R5

  AST_RW_NEEDS_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_rw |-> ((($past(bank_active_o) >> bank_o) & NBANK'(1)) != '0)); // R6

  AST_ACT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_o && cmd_o == C_ACT) |-> (((bank_active_o >> bank_o) & NBANK'(1)) != '0)); // R6

  AST_AP_ONLY_RW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_o |-> (cmd_o == C_READ || cmd_o == C_WRITE)); // R3

  AST_PREALL_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_o && cmd_o == C_PREALL) |-> (bank_active_o == '0)); // R3

  AST_ERR_HOLDS_BANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && cmd_o == C_ACT) |-> (bank_active_o == $past(bank_active_o))); // R10
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.BANK_W(BANK_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_o         (cmd_o),
  .bank_o        (bank_o),
  .ap_o          (ap_o),
  .err_o         (err_o),
  .bank_active_o (bank_active_o)
);

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;
  localparam logic [4:0] DESEL = 0, NOP = 1, MRS = 2, EMRS = 3, ACT = 4, RD = 5, WR = 6,
                         PRE = 7, PREALL = 8, REF = 9, BST = 10, SREF_IN = 11,
                         SREF_OUT = 12, PDN_IN = 13, PDN_OUT = 14, DPD_IN = 15,
                         DPD_OUT = 16, LOWPWR = 17;

  logic        clk = 0, rst_ni = 0;
  logic        cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0]  ba = 0;
  logic [11:0] addr = 0;
  logic [4:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [11:0] row_o;
  logic [9:0]  col_o;
  logic        ap_o, err_o;
  logic [3:0]  act_o;
  int          n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  sdram_cmd_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr), .cmd_o(cmd_o),
    .bank_o(bank_o), .row_o(row_o), .col_o(col_o), .ap_o(ap_o), .err_o(err_o),
    .bank_active_o(act_o)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_state(string req, logic [4:0] c, logic e, logic [3:0] a);
    check(req, "cmd", cmd_o, c);
    check(req, "err", err_o, e);
    check(req, "banks", act_o, a);
  endtask

  // drive at negedge, sample 1ns after the next posedge
  task automatic pins(logic k, logic s, logic r, logic c, logic w, logic [1:0] b, logic [11:0] a);
    @(negedge clk);
    cke = k; cs_n = s; ras_n = r; cas_n = c; we_n = w; ba = b; addr = a;
    @(posedge clk); #1;
  endtask

  task automatic nop();                    pins(1, 0, 1, 1, 1, 0, 0); endtask
  task automatic mrs(logic [1:0] b, logic [11:0] a); pins(1, 0, 0, 0, 0, b, a); endtask
  task automatic act(logic [1:0] b, logic [11:0] r); pins(1, 0, 0, 1, 1, b, r); endtask
  task automatic rd(logic [1:0] b, logic [11:0] a);  pins(1, 0, 1, 0, 1, b, a); endtask
  task automatic wr(logic [1:0] b, logic [11:0] a);  pins(1, 0, 1, 0, 0, b, a); endtask
  task automatic pre(logic [1:0] b, logic [11:0] a); pins(1, 0, 0, 1, 0, b, a); endtask
  task automatic refr();                   pins(1, 0, 0, 0, 1, 0, 0); endtask

  task automatic t_reset();
    expect_state("R10", DESEL, 0, 4'b0000);
  endtask

  task automatic t_mode_hold();
    mrs(0, 12'h002);                 // BL4
    expect_state("R1", MRS, 0, 4'b0000);
    act(0, 12'h5A5);
    expect_state("R5", ACT, 1, 4'b0000);   // R10 bank unchanged
    nop();
    expect_state("R5", NOP, 0, 4'b0000);
    act(0, 12'h5A5);
    expect_state("R6", ACT, 0, 4'b0001);
    check("R3", "row", row_o, 12'h5A5);
  endtask

  task automatic t_idle_rule();
    mrs(0, 12'h003);
    expect_state("R4", MRS, 1, 4'b0001);
    refr();
    expect_state("R4", REF, 1, 4'b0001);
    act(1, 12'h010);
    expect_state("R6", ACT, 0, 4'b0011);
    rd(2, 12'h000);
    expect_state("R6", RD, 1, 4'b0011);
    rd(0, 12'h155);
    expect_state("R3", RD, 0, 4'b0011);
    check("R3", "col", col_o, 10'h155);
    check("R3", "ap", ap_o, 0);
  endtask

  task automatic t_auto_pre();
    wr(0, 12'h400 | 12'h022);
    expect_state("R7", WR, 0, 4'b0011);
    check("R3", "ap", ap_o, 1);
    check("R3", "col", col_o, 10'h022);
    rd(0, 12'h000);
    expect_state("R7", RD, 1, 4'b0011);
    rd(1, 12'h004);
    expect_state("R7", RD, 0, 4'b0011);
    check("R3", "bank", bank_o, 1);
    pre(1, 12'h000);
    expect_state("R6", PRE, 0, 4'b0001);
    nop();
    expect_state("R8", NOP, 0, 4'b0001);
    refr();                          // lands on the closing edge
    expect_state("R7", REF, 1, 4'b0000);
    refr();
    expect_state("R4", REF, 0, 4'b0000);
  endtask

  task automatic t_burst8();
    mrs(0, 12'h003);
    expect_state("R8", MRS, 0, 4'b0000);
    nop(); nop();
    act(2, 12'h001);
    expect_state("R6", ACT, 0, 4'b0100);
    rd(2, 12'h400);
    expect_state("R8", RD, 0, 4'b0100);
    for (int i = 0; i < 8; i++) nop();
    check("R8", "bank2 open at 8", act_o[2], 1);
    nop();
    check("R8", "bank2 closed at 9", act_o[2], 0);
  endtask

  task automatic t_decode();
    mrs(2, 12'h000);
    expect_state("R1", EMRS, 0, 4'b0000);
    pins(1, 0, 1, 1, 0, 0, 0);
    expect_state("R5", BST, 1, 4'b0000);
    nop();
    pins(1, 0, 1, 1, 0, 0, 0);
    expect_state("R1", BST, 0, 4'b0000);
    pins(1, 1, 0, 0, 0, 0, 0);
    expect_state("R1", DESEL, 0, 4'b0000);
    act(3, 12'h0FF);
    act(0, 12'h0FF);
    expect_state("R6", ACT, 0, 4'b1001);
    pre(1, 12'h400);
    expect_state("R3", PREALL, 0, 4'b0000);
  endtask

  task automatic t_low_power();
    pins(0, 0, 0, 0, 1, 0, 0);
    expect_state("R2", SREF_IN, 0, 4'b0000);
    pins(0, 0, 1, 1, 1, 0, 0);
    expect_state("R2", LOWPWR, 0, 4'b0000);
    nop();
    expect_state("R2", SREF_OUT, 0, 4'b0000);
    pins(0, 0, 1, 1, 1, 0, 0);
    expect_state("R2", PDN_IN, 0, 4'b0000);
    nop();
    expect_state("R2", PDN_OUT, 0, 4'b0000);
    act(1, 12'h000);
    pins(0, 0, 0, 0, 1, 0, 0);
    expect_state("R4", SREF_IN, 1, 4'b0010);
    nop();
    expect_state("R2", SREF_OUT, 0, 4'b0010);
    pre(0, 12'h400);
  endtask

  task automatic t_deep_pd();
    act(3, 12'h000);
    pins(0, 0, 1, 1, 0, 0, 0);
    expect_state("R2", DPD_IN, 0, 4'b1000);
    nop();
    expect_state("R9", DPD_OUT, 0, 4'b0000);
    act(0, 12'h000);
    expect_state("R9", ACT, 1, 4'b0000);
    nop();
    expect_state("R9", NOP, 0, 4'b0000);
    mrs(0, 12'h001);
    expect_state("R9", MRS, 0, 4'b0000);
    nop(); nop();
    act(0, 12'h000);
    expect_state("R9", ACT, 0, 4'b0001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk) rst_ni = 1;
    t_mode_hold();
    t_idle_rule();
    t_auto_pre();
    t_burst8();
    t_decode();
    t_low_power();
    t_deep_pd();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule